// File: doc/BRIEF.md
# Dual-Port Block Memory with Per-Port Write-Cycle Read Behaviour

This block is an on-chip memory of 18 Kbit for parity-capable widths (16 Kbit for the narrow widths). A parameter sets the word width, and the depth follows from it. A second parameter sets how the two ports are used. In true dual-port use both ports read and write. In pseudo dual-port use port A only writes and port B only reads. In single-port use only port A is active. Both ports run on one shared clock. Each port has its own enable, write enable, address, write data, read data and parity-error flag.

Each port has its own parameter that decides what its read register shows on an enabled write cycle:
- it keeps its previous value;
- it shows the word being written; or
- it shows the word that was stored before the write.

At the 9, 18 and 36-bit widths each 9-bit lane holds eight data bits and one even-parity bit, all supplied by the writer. Every value loaded into a read register is checked lane by lane, and the result is flagged in the same cycle as the data.

Top module: `brm_top`

## Requirements
- R1: The depth is 16384/DATA_W for DATA_W of 1, 2 or 4, and 18432/DATA_W for DATA_W of 9, 18 or 36. Any other width stops elaboration. The highest address (DEPTH-1) stores a word independently of address 0.
- R2: On an edge where a port is enabled and not writing, that port's read data takes the stored word at its address; the value is visible after that edge. While a port is disabled, its read data holds.
- R3: In the keep-output write mode, an enabled write leaves that port's read data unchanged. A later read of the address returns the written word.
- R4: In the show-new-data write mode, an enabled write loads that port's read data with the write data on the same edge.
- R5: In the show-old-data write mode, an enabled write loads that port's read data with the address's contents from before the write. This mode at a width other than 9, 18 or 36 stops elaboration.
- R6: At widths 9, 18 and 36, lane k is bits 9k+8 down to 9k, and a lane is correct when it holds an even number of ones. The parity-error flag is 1 together with a loaded word in which any lane holds an odd number of ones, and 0 otherwise. At widths 1, 2 and 4 the flag is always 0.
- R7: When both ports write the same address on the same edge, the word from port A is stored.
- R8: A read on one port of the address that the other port writes on the same edge returns the word from before the write.
- R9: In pseudo dual-port use, port A's read data stays 0 and port B's write enable is ignored, so an enabled port B cycle is a read.
- R10: In single-port use, every port B input is ignored and port B's read data and flag stay 0.
- R11: While the active-low reset is held, both read data outputs and both parity-error flags are 0. The reset does not clear the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rstN | input | 1 | Asynchronous active-low reset of the read registers |
| enA | input | 1 | Port A cycle enable |
| weA | input | 1 | Port A write enable |
| addrA | input | ADDR_W | Port A word address |
| dinA | input | DATA_W | Port A write data |
| doutA | output | DATA_W | Port A registered read data |
| parErrA | output | 1 | Port A parity error for doutA |
| enB | input | 1 | Port B cycle enable |
| weB | input | 1 | Port B write enable |
| addrB | input | ADDR_W | Port B word address |
| dinB | input | DATA_W | Port B write data |
| doutB | output | DATA_W | Port B registered read data |
| parErrB | output | 1 | Port B parity error for doutB |

## Verification
Two pairs of operations can land on the same edge:
- a write on both ports to one address;
- a write on one port and a read of that same address on the other.

The bench first writes a known word to the address through port A. It then drives both ports in a single negedge-to-negedge window. Port B runs in the show-old-data mode, so its read register must carry the prior word in both cases. A following read through port A must return A's word after the double write, and a read through B must return the new word after the mixed cycle.

// File: rtl/brm_pkg.sv
package brm_pkg;

  typedef enum logic [1:0] {
    CFG_TRUE_DP   = 2'd0,
    CFG_PSEUDO_DP = 2'd1,
    CFG_SINGLE    = 2'd2
  } port_cfg_e;

  typedef enum logic [1:0] {
    WM_NORMAL     = 2'd0,
    WM_THROUGH    = 2'd1,
    WM_READ_FIRST = 2'd2
  } wmode_e;

  // strobes from control to datapath for one clock edge
  typedef struct packed {
    logic wrA;
    logic wrB;
    logic ldA;
    logic ldB;
    logic thruA;
    logic thruB;
  } brm_strobe_t;

  function automatic bit hasPar(input int w);
    return (w == 9) || (w == 18) || (w == 36);
  endfunction

  function automatic bit legalWidth(input int w);
    return (w == 1) || (w == 2) || (w == 4) || hasPar(w);
  endfunction

  function automatic int depthOf(input int w);
    if (w <= 0) return 1;
    return hasPar(w) ? (18432 / w) : (16384 / w);
  endfunction

endpackage

// File: rtl/brm_parity.sv
module brm_parity #(
  parameter int DATA_W = 18,
  localparam bit HAS_PAR = brm_pkg::hasPar(DATA_W),
  localparam int LANES = HAS_PAR ? DATA_W / 9 : 1
) (
  input  logic [DATA_W-1:0] word,
  output logic              err
);

  generate
    if (HAS_PAR) begin : gPar
      logic [LANES-1:0] laneBad;
      for (genvar k = 0; k < LANES; k++) begin : gLane
        assign laneBad[k] = ^word[k*9 +: 9];
      end
      assign err = |laneBad;
    end else begin : gNoPar
      logic unusedWord;
      assign unusedWord = ^word;
      assign err = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/brm_ctrl.sv
module brm_ctrl
  import brm_pkg::*;
#(
  parameter port_cfg_e PORT_CFG = CFG_TRUE_DP,
  parameter wmode_e    WMODE_A  = WM_NORMAL,
  parameter wmode_e    WMODE_B  = WM_READ_FIRST,
  parameter int        ADDR_W   = 10
) (
  input  logic              enA,
  input  logic              weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic              enB,
  input  logic              weB,
  input  logic [ADDR_W-1:0] addrB,
  output brm_strobe_t       stb
);

  localparam bit A_READS  = (PORT_CFG != CFG_PSEUDO_DP);
  localparam bit B_ACTIVE = (PORT_CFG != CFG_SINGLE);
  localparam bit B_WRITES = (PORT_CFG == CFG_TRUE_DP);

  logic aWrite;
  logic bOn;
  logic bWrite;
  logic sameAddr;

  always_comb begin
    aWrite   = enA && weA;
    bOn      = B_ACTIVE && enB;
    bWrite   = bOn && B_WRITES && weB;
    sameAddr = (addrA == addrB);

    stb       = '0;
    stb.wrA   = aWrite;
    // port A wins an address collision
    stb.wrB   = bWrite && !(aWrite && sameAddr);
    stb.ldA   = A_READS && enA && (!weA || (WMODE_A != WM_NORMAL));
    stb.thruA = weA && (WMODE_A == WM_THROUGH);
    stb.ldB   = bOn && (!bWrite || (WMODE_B != WM_NORMAL));
    stb.thruB = bWrite && (WMODE_B == WM_THROUGH);
  end

endmodule

// File: rtl/brm_datapath.sv
module brm_datapath
  import brm_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  brm_strobe_t       stb,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] dinA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] dinB,
  output logic [DATA_W-1:0] doutA,
  output logic              perrA,
  output logic [DATA_W-1:0] doutB,
  output logic              perrB
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] oldA;
  logic [DATA_W-1:0] oldB;
  logic [DATA_W-1:0] nxtA;
  logic [DATA_W-1:0] nxtB;
  logic              nxtErrA;
  logic              nxtErrB;

  always_comb begin
    oldA = mem[addrA];
    oldB = mem[addrB];
    nxtA = stb.thruA ? dinA : oldA;
    nxtB = stb.thruB ? dinB : oldB;
  end

  brm_parity #(.DATA_W(DATA_W)) uParA (.word(nxtA), .err(nxtErrA));
  brm_parity #(.DATA_W(DATA_W)) uParB (.word(nxtB), .err(nxtErrB));

  // the array is read before it is updated, which gives show-old-data for free
  always_ff @(posedge clk) begin
    if (stb.wrA) mem[addrA] <= dinA;
    if (stb.wrB) mem[addrB] <= dinB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutA <= '0;
      perrA <= 1'b0;
    end else if (stb.ldA) begin
      doutA <= nxtA;
      perrA <= nxtErrA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutB <= '0;
      perrB <= 1'b0;
    end else if (stb.ldB) begin
      doutB <= nxtB;
      perrB <= nxtErrB;
    end
  end

  // R7
  a_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrA && stb.wrB) |-> (addrA != addrB));

  // R2
  hold_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldA |=> $stable(doutA));

  // R2
  hold_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldB |=> $stable(doutB));

endmodule

// File: rtl/brm_top.sv
module brm_top
  import brm_pkg::*;
#(
  parameter int        DATA_W   = 18,
  parameter port_cfg_e PORT_CFG = CFG_TRUE_DP,
  parameter wmode_e    WMODE_A  = WM_NORMAL,
  parameter wmode_e    WMODE_B  = WM_READ_FIRST,
  localparam int       DEPTH    = brm_pkg::depthOf(DATA_W),
  localparam int       ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enA,
  input  logic              weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] dinA,
  output logic [DATA_W-1:0] doutA,
  output logic              parErrA,
  input  logic              enB,
  input  logic              weB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] dinB,
  output logic [DATA_W-1:0] doutB,
  output logic              parErrB
);

  localparam bit HAS_PAR = brm_pkg::hasPar(DATA_W);

  generate
    if (!brm_pkg::legalWidth(DATA_W)) begin : gBadWidth
      $error("brm_top: DATA_W must be 1, 2, 4, 9, 18 or 36");
    end
    if (!HAS_PAR && ((WMODE_A == WM_READ_FIRST) || (WMODE_B == WM_READ_FIRST)))
    begin : gBadMode
      $error("brm_top: show-old-data write mode needs width 9, 18 or 36");
    end
  endgenerate

  brm_strobe_t stb;

  brm_ctrl #(
    .PORT_CFG(PORT_CFG),
    .WMODE_A (WMODE_A),
    .WMODE_B (WMODE_B),
    .ADDR_W  (ADDR_W)
  ) uCtrl (
    .enA  (enA),
    .weA  (weA),
    .addrA(addrA),
    .enB  (enB),
    .weB  (weB),
    .addrB(addrB),
    .stb  (stb)
  );

  brm_datapath #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) uDp (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .addrA(addrA),
    .dinA (dinA),
    .addrB(addrB),
    .dinB (dinB),
    .doutA(doutA),
    .perrA(parErrA),
    .doutB(doutB),
    .perrB(parErrB)
  );

  // R3
  normal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((WMODE_A == WM_NORMAL) && enA && weA) |=> $stable(doutA));

  // R4
  through_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((WMODE_A == WM_THROUGH) && (PORT_CFG != CFG_PSEUDO_DP) && enA && weA)
      |=> (doutA == $past(dinA)));

  // R9
  pseudo_a_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (PORT_CFG == CFG_PSEUDO_DP) |-> (doutA == '0));

  // R10
  single_b_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (PORT_CFG == CFG_SINGLE) |-> ((doutB == '0) && !parErrB));

  // R6
  no_par_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !HAS_PAR |-> (!parErrA && !parErrB));

endmodule

// File: tb/brm_top_test.sv
module brm_top_test;
  import brm_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  // uut: true dual-port, 18 bits, A keep-output, B show-old-data
  logic aEn = 0, aWe = 0, bEn = 0, bWe = 0;
  logic [9:0]  aAddr = '0, bAddr = '0;
  logic [17:0] aDin = '0, bDin = '0, aDout, bDout;
  logic aPe, bPe;

  // uutPs: pseudo dual-port, 9 bits
  logic pAEn = 0, pAWe = 0, pBEn = 0, pBWe = 0;
  logic [10:0] pAAddr = '0, pBAddr = '0;
  logic [8:0]  pADin = '0, pBDin = '0, pADout, pBDout;
  logic pAPe, pBPe;

  // uutSp: single-port, 36 bits, A show-new-data
  logic sAEn = 0, sAWe = 0, sBEn = 0, sBWe = 0;
  logic [8:0]  sAAddr = '0, sBAddr = '0;
  logic [35:0] sADin = '0, sBDin = '0, sADout, sBDout;
  logic sAPe, sBPe;

  brm_top uut (
    .clk(clk), .rstN(rstN),
    .enA(aEn), .weA(aWe), .addrA(aAddr), .dinA(aDin), .doutA(aDout), .parErrA(aPe),
    .enB(bEn), .weB(bWe), .addrB(bAddr), .dinB(bDin), .doutB(bDout), .parErrB(bPe)
  );

  brm_top #(.DATA_W(9), .PORT_CFG(CFG_PSEUDO_DP), .WMODE_A(WM_NORMAL),
            .WMODE_B(WM_READ_FIRST)) uutPs (
    .clk(clk), .rstN(rstN),
    .enA(pAEn), .weA(pAWe), .addrA(pAAddr), .dinA(pADin), .doutA(pADout), .parErrA(pAPe),
    .enB(pBEn), .weB(pBWe), .addrB(pBAddr), .dinB(pBDin), .doutB(pBDout), .parErrB(pBPe)
  );

  brm_top #(.DATA_W(36), .PORT_CFG(CFG_SINGLE), .WMODE_A(WM_THROUGH),
            .WMODE_B(WM_NORMAL)) uutSp (
    .clk(clk), .rstN(rstN),
    .enA(sAEn), .weA(sAWe), .addrA(sAAddr), .dinA(sADin), .doutA(sADout), .parErrA(sAPe),
    .enB(sBEn), .weB(sBWe), .addrB(sBAddr), .dinB(sBDin), .doutB(sBDout), .parErrB(sBPe)
  );

  // even-parity lane: ninth bit makes the count of ones even unless bad is set
  function automatic logic [8:0] ln(input logic [7:0] d, input logic bad);
    return {(^d) ^ bad, d};
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic stepU(input logic eA, input logic wA, input logic [9:0] adA,
                       input logic [17:0] dA, input logic eB, input logic wB,
                       input logic [9:0] adB, input logic [17:0] dB);
    @(negedge clk);
    aEn = eA; aWe = wA; aAddr = adA; aDin = dA;
    bEn = eB; bWe = wB; bAddr = adB; bDin = dB;
    @(negedge clk);
    aEn = 0; aWe = 0; bEn = 0; bWe = 0;
  endtask

  task automatic stepP(input logic eA, input logic wA, input logic [10:0] adA,
                       input logic [8:0] dA, input logic eB, input logic wB,
                       input logic [10:0] adB, input logic [8:0] dB);
    @(negedge clk);
    pAEn = eA; pAWe = wA; pAAddr = adA; pADin = dA;
    pBEn = eB; pBWe = wB; pBAddr = adB; pBDin = dB;
    @(negedge clk);
    pAEn = 0; pAWe = 0; pBEn = 0; pBWe = 0;
  endtask

  task automatic stepS(input logic eA, input logic wA, input logic [8:0] adA,
                       input logic [35:0] dA, input logic eB, input logic wB,
                       input logic [8:0] adB, input logic [35:0] dB);
    @(negedge clk);
    sAEn = eA; sAWe = wA; sAAddr = adA; sADin = dA;
    sBEn = eB; sBWe = wB; sBAddr = adB; sBDin = dB;
    @(negedge clk);
    sAEn = 0; sAWe = 0; sBEn = 0; sBWe = 0;
  endtask

  task automatic testReset();
    // R11: outputs are zero while reset is held
    chk("R11 doutA", aDout, 0);
    chk("R11 doutB", bDout, 0);
    chk("R11 parErr", {aPe, bPe}, 0);
    chk("R11 pseudo doutB", pBDout, 0);
    chk("R11 single doutA", sADout, 0);
  endtask

  task automatic testNormalAndRead();
    logic [17:0] p = {ln(8'h12, 0), ln(8'h34, 0)};
    logic [17:0] q = {ln(8'hA5, 0), ln(8'h0F, 0)};
    stepU(1, 1, 10'd1, p, 0, 0, 0, 0);
    stepU(1, 0, 10'd1, 0, 0, 0, 0, 0);
    chk("R2 read after write", aDout, p);
    stepU(1, 1, 10'd1, q, 0, 0, 0, 0);
    chk("R3 keep output on write", aDout, p);
    stepU(0, 0, 10'd2, 0, 0, 0, 0, 0);
    chk("R2 disabled port holds", aDout, p);
    stepU(1, 0, 10'd1, 0, 0, 0, 0, 0);
    chk("R3 later read sees write", aDout, q);
  endtask

  task automatic testReadFirst();
    logic [17:0] q = {ln(8'hA5, 0), ln(8'h0F, 0)};
    logic [17:0] r = {ln(8'h77, 0), ln(8'h81, 0)};
    stepU(0, 0, 0, 0, 1, 1, 10'd1, r);
    chk("R5 old data on write", bDout, q);
    stepU(0, 0, 0, 0, 1, 0, 10'd1, 0);
    chk("R5 new data stored", bDout, r);
  endtask

  task automatic testCollision();
    logic [17:0] v0 = {ln(8'h01, 0), ln(8'h02, 0)};
    logic [17:0] v1 = {ln(8'h11, 0), ln(8'h22, 0)};
    logic [17:0] v2 = {ln(8'h33, 0), ln(8'h44, 0)};
    stepU(1, 1, 10'd7, v0, 0, 0, 0, 0);
    stepU(1, 1, 10'd7, v1, 1, 1, 10'd7, v2);
    chk("R8 B sees old on double write", bDout, v0);
    stepU(1, 0, 10'd7, 0, 0, 0, 0, 0);
    chk("R7 port A wins", aDout, v1);
  endtask

  task automatic testCrossRead();
    logic [17:0] v0 = {ln(8'hC0, 0), ln(8'h03, 0)};
    logic [17:0] v3 = {ln(8'h5A, 0), ln(8'hE1, 0)};
    stepU(1, 1, 10'd9, v0, 0, 0, 0, 0);
    stepU(1, 1, 10'd9, v3, 1, 0, 10'd9, 0);
    chk("R8 read during other write", bDout, v0);
    stepU(0, 0, 0, 0, 1, 0, 10'd9, 0);
    chk("R8 next read sees write", bDout, v3);
  endtask

  task automatic testParity();
    logic [17:0] bad = {ln(8'h6B, 1), ln(8'h10, 0)};
    logic [17:0] good = {ln(8'h6B, 0), ln(8'h10, 0)};
    stepU(1, 1, 10'd3, bad, 0, 0, 0, 0);
    stepU(1, 0, 10'd3, 0, 0, 0, 0, 0);
    chk("R6 bad lane data", aDout, bad);
    chk("R6 flag set", aPe, ^bad[17:9] | ^bad[8:0]);
    stepU(1, 1, 10'd4, good, 0, 0, 0, 0);
    stepU(1, 0, 10'd4, 0, 0, 0, 0, 0);
    chk("R6 flag clear", aPe, 0);
  endtask

  task automatic testBoundary();
    logic [17:0] hi = {ln(8'hFE, 0), ln(8'hDC, 0)};
    logic [17:0] lo = {ln(8'h0A, 0), ln(8'h0B, 0)};
    stepU(1, 1, 10'd1023, hi, 0, 0, 0, 0);
    stepU(1, 1, 10'd0, lo, 0, 0, 0, 0);
    stepU(1, 0, 10'd1023, 0, 0, 0, 0, 0);
    chk("R1 top address", aDout, hi);
    stepU(1, 0, 10'd0, 0, 0, 0, 0, 0);
    chk("R1 address zero", aDout, lo);
  endtask

  task automatic testPseudo();
    logic [8:0] w = ln(8'h5A, 0);
    stepP(1, 1, 11'd2047, w, 0, 0, 0, 0);
    chk("R9 port A read data stays zero", pADout, 0);
    stepP(1, 0, 11'd2047, 0, 0, 0, 0, 0);
    chk("R9 port A read ignored", pADout, 0);
    stepP(0, 0, 0, 0, 1, 1, 11'd2047, ln(8'h33, 0));
    chk("R9 B write enable acts as read", pBDout, w);
    stepP(0, 0, 0, 0, 1, 0, 11'd2047, 0);
    chk("R9 B write ignored", pBDout, w);
  endtask

  task automatic testSingle();
    logic [35:0] v  = {ln(8'h11, 0), ln(8'h22, 0), ln(8'h33, 0), ln(8'h44, 0)};
    logic [35:0] v2 = {ln(8'h99, 0), ln(8'h88, 0), ln(8'h77, 0), ln(8'h66, 0)};
    logic [35:0] z  = {ln(8'hFF, 0), ln(8'hFF, 0), ln(8'hFF, 0), ln(8'hFF, 0)};
    stepS(1, 1, 9'd511, v, 1, 1, 9'd511, z);
    chk("R4 new data on write", sADout, v);
    chk("R10 port B quiet", sBDout, 0);
    stepS(1, 1, 9'd0, v2, 0, 0, 0, 0);
    chk("R4 new data on second write", sADout, v2);
    stepS(1, 0, 9'd511, 0, 0, 0, 0, 0);
    chk("R1 single top address / R10 B write ignored", sADout, v);
    stepS(0, 0, 0, 0, 1, 0, 9'd511, 0);
    chk("R10 port B read ignored", {sBPe, sBDout}, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testNormalAndRead();
    testReadFirst();
    testCollision();
    testCrossRead();
    testParity();
    testBoundary();
    testPseudo();
    testSingle();
    finishRun();
  end

endmodule